// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block is the control path that moves an 8-bit processor into a reset, non-maskable interrupt or maskable interrupt handler. It keeps the pending requests, picks one at each instruction boundary, and then runs a fixed seven-cycle sequence. That sequence saves the return context on a stack that grows downward in page one and fetches the handler address from a two-byte vector. The opcode engine does not belong to the block. The core reports each instruction boundary with a strobe and presents its PC, status byte and stack pointer at that moment. It takes the updated values back once `busy` drops.

Maskable requests come from several independent level sources, one bit each. A non-maskable request is a single strobe that stays latched until it is serviced. The core can signal a jam (a halted, locked-up condition), and after a jam nothing is accepted until the next reset. Masking follows the interrupt-disable flag as it stood before the instruction that just ended, not as it stands now.

Top module: `irq_entry_seq`

## Requirements
- R1: After `rst_n` rises, `busy` stays high for 7 cycles, counting the cycle in which `rst_n` is first seen high. During that time there are no writes. In the 6th busy cycle the block reads 0xFFFC and in the 7th it reads 0xFFFD. After that, `pc_out` holds {byte at 0xFFFD, byte at 0xFFFC}, `status_out` is 0x04, `sp_out` is 0x00, and the jam condition, the source bits and any latched non-maskable request are all cleared.
- R2: An accepted boundary makes `busy` high for exactly 7 cycles, starting on the next clock. The three stack writes fall in busy cycles 3, 4 and 5 (counting from 1). The two vector reads fall in cycles 6 and 7. `mem_rd` and `mem_wr` are never high together.
- R3: Let S be `sp_in`. The writes go to 0x0100+S, 0x0100+S-1 and 0x0100+S-2, with the low byte wrapping within page one. `sp_out` ends at S-3 modulo 256.
- R4: The write data are, in order: PC bits 15:8, PC bits 7:0, then `status_in` with bit 4 cleared and bit 5 set. The resulting `status_out` also has bit 4 cleared.
- R5: A non-maskable entry reads 0xFFFA and then 0xFFFB. `pc_out` becomes {byte at 0xFFFB, byte at 0xFFFA}, and status bit 2 is left as it was.
- R6: A maskable entry reads 0xFFFE and then 0xFFFF. `pc_out` becomes {byte at 0xFFFF, byte at 0xFFFE}, and status bit 2 is set.
- R7: When both kinds are pending at a boundary, the non-maskable one is taken. The maskable request stays pending and can be taken at a later boundary.
- R8: A maskable request is taken only if status bit 2 is clear in the mask reference. At an idle boundary the mask reference becomes bit 2 of the `status_in` presented at that boundary. After an entry or a reset, it becomes bit 2 of the resulting `status_out`.
- R9: Each source bit is updated one clock after the request: cleared by `irq_clr`, set by `irq_set`, with set winning when both are given. `irq_pending` is the OR of the bits, and a source bit stays set until its own source clears it.
- R10: A `nmi_req` strobe is held until a non-maskable entry is accepted, and that entry consumes it. A following boundary with nothing else pending then starts no entry.
- R11: After a `jam_strobe`, no boundary starts an entry until the next reset.
- R12: An `insn_boundary` that arrives while `busy` is high is ignored. A boundary with nothing eligible leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the reset vector fetch begins when it is released |
| insn_boundary | input | 1 | One-cycle strobe at each instruction boundary |
| pc_in | input | 16 | Core PC at the boundary |
| status_in | input | 8 | Core status byte at the boundary (bit 2 interrupt disable) |
| sp_in | input | 8 | Core stack pointer at the boundary |
| irq_set | input | IRQ_SOURCES | Per-source assert strobes |
| irq_clr | input | IRQ_SOURCES | Per-source release strobes |
| nmi_req | input | 1 | Non-maskable request strobe |
| jam_strobe | input | 1 | Core reports a jam |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| mem_rd | output | 1 | Vector read strobe |
| mem_wr | output | 1 | Stack write strobe |
| mem_addr | output | 16 | Address for the read or write |
| mem_wdata | output | 8 | Stack write data |
| pc_out | output | 16 | PC after the last entry or reset |
| status_out | output | 8 | Status after the last entry or reset |
| sp_out | output | 8 | Stack pointer after the last entry or reset |
| busy | output | 1 | A sequence is running |
| irq_pending | output | 1 | At least one source bit is set |

## Verification
A boundary strobe is sampled on one rising edge, and `busy` is seen high one clock later. From that first busy cycle the bench samples on every falling edge and logs which busy cycle each write or read lands in. It then checks the updated PC, status and stack pointer on the first falling edge where `busy` is low again. Source bit changes reach `irq_pending` one clock after the strobe. The bench reads that flag on the falling edge after the strobe, and its boundary model uses the same one-cycle lag to predict whether an entry starts.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;

    typedef enum logic [1:0] {
        SVC_NONE  = 2'd0,
        SVC_RESET = 2'd1,
        SVC_NMI   = 2'd2,
        SVC_IRQ   = 2'd3
    } svc_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_VLO  = 2'd2,
        OP_VHI  = 2'd3
    } memop_e;

    localparam int          ENTRY_CYCLES = 7;
    localparam int          STEP_W       = $clog2(ENTRY_CYCLES);
    localparam int          FLAG_I       = 2;
    localparam int          FLAG_B       = 4;
    localparam int          FLAG_U       = 5;
    localparam logic [7:0]  STACK_PAGE   = 8'h01;
    localparam logic [7:0]  STATUS_AT_RST = 8'h04;
    localparam logic [15:0] VEC_NMI      = 16'hFFFA;
    localparam logic [15:0] VEC_RESET    = 16'hFFFC;
    localparam logic [15:0] VEC_IRQ      = 16'hFFFE;

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        svc_e              kind;
        logic [15:0]       pc;
        logic [7:0]        st;
        logic [7:0]        sp;
        logic              jam;
        logic              nmi_pend;
        logic              i_before;
    } seq_state_t;

    function automatic logic [15:0] vector_of(input svc_e k);
        case (k)
            SVC_NMI: return VEC_NMI;
            SVC_IRQ: return VEC_IRQ;
            default: return VEC_RESET;
        endcase
    endfunction

endpackage

// File: rtl/irq_src_mask.sv
`timescale 1ns/1ps
module irq_src_mask #(
    parameter int SOURCES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SOURCES-1:0] set_i,
    input  logic [SOURCES-1:0] clr_i,
    output logic [SOURCES-1:0] bits_o,
    output logic               any_o
);
    logic [SOURCES-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = (bits_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits_o = bits_q;
    assign any_o  = |bits_q;

    for (genvar g = 0; g < SOURCES; g++) begin : g_src_chk
        // R9
        src_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !bits_o[g]);
        // R9
        src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bits_o[g] && !clr_i[g]) |=> bits_o[g]);
    end
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick
    import irq_seq_pkg::*;
(
    input  logic boundary_i,
    input  logic busy_i,
    input  logic jammed_i,
    input  logic nmi_pend_i,
    input  logic irq_any_i,
    input  logic i_before_i,
    output logic take_o,
    output svc_e pick_o,
    output logic idle_o
);
    logic open_w, want_nmi, want_irq;

    always_comb begin
        open_w   = boundary_i && !busy_i;
        want_nmi = open_w && !jammed_i && nmi_pend_i;
        want_irq = open_w && !jammed_i && !nmi_pend_i && irq_any_i && !i_before_i;
        take_o   = want_nmi || want_irq;
        idle_o   = open_w && !take_o;
        if (want_nmi)      pick_o = SVC_NMI;
        else if (want_irq) pick_o = SVC_IRQ;
        else               pick_o = SVC_NONE;
    end
endmodule

// File: rtl/irq_step_plan.sv
`timescale 1ns/1ps
module irq_step_plan
    import irq_seq_pkg::*;
#(
    parameter int CYCLES = ENTRY_CYCLES,
    parameter int SW     = STEP_W
) (
    input  logic          busy_i,
    input  logic [SW-1:0] step_i,
    input  svc_e          kind_i,
    output memop_e        op_o,
    output logic [1:0]    slot_o
);
    localparam int PUSH_FIRST = CYCLES - 5;
    localparam logic [SW-1:0] STEP_VHI = SW'(CYCLES - 1);
    localparam logic [SW-1:0] STEP_VLO = SW'(CYCLES - 2);
    localparam logic [SW-1:0] STEP_P0  = SW'(PUSH_FIRST);

    logic [SW-1:0] rel;

    always_comb begin
        op_o   = OP_IDLE;
        slot_o = 2'd0;
        rel    = step_i - STEP_P0;
        if (busy_i) begin
            if (step_i == STEP_VHI)      op_o = OP_VHI;
            else if (step_i == STEP_VLO) op_o = OP_VLO;
            else if (step_i >= STEP_P0 && kind_i != SVC_RESET) begin
                op_o   = OP_PUSH;
                slot_o = rel[1:0];
            end
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int IRQ_SOURCES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   insn_boundary,
    input  logic [15:0]            pc_in,
    input  logic [7:0]             status_in,
    input  logic [7:0]             sp_in,
    input  logic [IRQ_SOURCES-1:0] irq_set,
    input  logic [IRQ_SOURCES-1:0] irq_clr,
    input  logic                   nmi_req,
    input  logic                   jam_strobe,
    input  logic [7:0]             mem_rdata,
    output logic                   mem_rd,
    output logic                   mem_wr,
    output logic [15:0]            mem_addr,
    output logic [7:0]             mem_wdata,
    output logic [15:0]            pc_out,
    output logic [7:0]             status_out,
    output logic [7:0]             sp_out,
    output logic                   busy,
    output logic                   irq_pending
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(ENTRY_CYCLES - 1);
    localparam logic [7:0] B_MASK = 8'(1 << FLAG_B);
    localparam logic [7:0] U_MASK = 8'(1 << FLAG_U);
    localparam logic [7:0] I_MASK = 8'(1 << FLAG_I);

    seq_state_t q, d;

    logic [IRQ_SOURCES-1:0] src_bits;
    logic                   irq_any;
    logic                   take, idle_bnd;
    svc_e                   pick;
    memop_e                 op;
    logic [1:0]             slot;

    irq_src_mask #(.SOURCES(IRQ_SOURCES)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (irq_clr),
        .bits_o (src_bits),
        .any_o  (irq_any)
    );

    irq_pick u_pick (
        .boundary_i (insn_boundary),
        .busy_i     (q.busy),
        .jammed_i   (q.jam),
        .nmi_pend_i (q.nmi_pend),
        .irq_any_i  (irq_any),
        .i_before_i (q.i_before),
        .take_o     (take),
        .pick_o     (pick),
        .idle_o     (idle_bnd)
    );

    irq_step_plan #(.CYCLES(ENTRY_CYCLES), .SW(STEP_W)) u_plan (
        .busy_i (q.busy),
        .step_i (q.step),
        .kind_i (q.kind),
        .op_o   (op),
        .slot_o (slot)
    );

    always_comb begin
        d          = q;
        d.jam      = q.jam | jam_strobe;
        d.nmi_pend = nmi_req | (q.nmi_pend & !(take && pick == SVC_NMI));

        if (idle_bnd) d.i_before = status_in[FLAG_I];

        if (take) begin
            d.busy = 1'b1;
            d.step = '0;
            d.kind = pick;
            d.pc   = pc_in;
            d.st   = status_in & ~B_MASK;
            d.sp   = sp_in;
        end else if (q.busy) begin
            d.step = q.step + 1'b1;
            case (op)
                OP_PUSH: d.sp = q.sp - 8'd1;
                OP_VLO:  d.pc[7:0] = mem_rdata;
                OP_VHI: begin
                    d.pc[15:8] = mem_rdata;
                    d.busy     = 1'b0;
                    d.step     = '0;
                    if (q.kind == SVC_IRQ) d.st = q.st | I_MASK;
                    d.i_before = (q.kind == SVC_IRQ) ? 1'b1 : q.st[FLAG_I];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.busy     <= 1'b1;
            q.step     <= '0;
            q.kind     <= SVC_RESET;
            q.pc       <= '0;
            q.st       <= STATUS_AT_RST;
            q.sp       <= '0;
            q.jam      <= 1'b0;
            q.nmi_pend <= 1'b0;
            q.i_before <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_rd    = (op == OP_VLO) || (op == OP_VHI);
        mem_wr    = (op == OP_PUSH);
        mem_addr  = '0;
        mem_wdata = '0;
        case (op)
            OP_PUSH: begin
                mem_addr = {STACK_PAGE, q.sp};
                case (slot)
                    2'd0:    mem_wdata = q.pc[15:8];
                    2'd1:    mem_wdata = q.pc[7:0];
                    default: mem_wdata = q.st | U_MASK;
                endcase
            end
            OP_VLO:  mem_addr = vector_of(q.kind);
            OP_VHI:  mem_addr = vector_of(q.kind) | 16'h0001;
            default: ;
        endcase
    end

    assign pc_out      = q.pc;
    assign status_out  = q.st;
    assign sp_out      = q.sp;
    assign busy        = q.busy;
    assign irq_pending = irq_any;

    // R2
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R2
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.step <= LAST_STEP));
    // R3
    push_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[15:8] == STACK_PAGE));
    // R3
    sp_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (sp_out == $past(sp_out) - 8'd1));
    // R1
    end_on_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(mem_rd) && $past(mem_addr[0])));
    // R7
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(q.nmi_pend)) |-> (q.kind == SVC_NMI));
    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && q.kind == SVC_IRQ) |-> !$past(q.i_before));
    // R11
    jam_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.jam && !busy) |=> !busy);
endmodule

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;
    localparam int SRC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic insn_boundary = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0] status_in = '0, sp_in = '0;
    logic [SRC-1:0] irq_set = '0, irq_clr = '0;
    logic nmi_req = 1'b0, jam_strobe = 1'b0;
    logic [7:0] mem_rdata;
    logic mem_rd, mem_wr, busy, irq_pending;
    logic [15:0] mem_addr, pc_out;
    logic [7:0] mem_wdata, status_out, sp_out;

    int checks = 0, failures = 0;
    bit finished = 0;

    // model state
    logic [SRC-1:0] m_bits = '0;
    bit m_nmi = 0, m_ib = 1, m_jam = 0;

    // sequence log
    int c_cyc, c_nw, c_nr;
    logic [15:0] w_addr [4];
    logic [7:0]  w_data [4];
    int          w_at   [4];
    logic [15:0] r_addr [4];
    int          r_at   [4];

    always #5 clk = ~clk;

    function automatic logic [7:0] vec_byte(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'hA5;
            16'hFFFB: return 8'hC3;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'h80;
            16'hFFFE: return 8'h17;
            16'hFFFF: return 8'h9E;
            default:  return a[7:0] ^ 8'h5A;
        endcase
    endfunction

    assign mem_rdata = mem_rd ? vec_byte(mem_addr) : 8'h00;

    irq_entry_seq #(.IRQ_SOURCES(SRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
        .pc_in(pc_in), .status_in(status_in), .sp_in(sp_in),
        .irq_set(irq_set), .irq_clr(irq_clr), .nmi_req(nmi_req),
        .jam_strobe(jam_strobe), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pc_out(pc_out), .status_out(status_out),
        .sp_out(sp_out), .busy(busy), .irq_pending(irq_pending)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic collect();
        c_cyc = 0; c_nw = 0; c_nr = 0;
        while (busy && c_cyc < 12) begin
            if (mem_wr) begin
                if (c_nw < 4) begin
                    w_addr[c_nw] = mem_addr; w_data[c_nw] = mem_wdata; w_at[c_nw] = c_cyc;
                end
                c_nw++;
            end
            if (mem_rd) begin
                if (c_nr < 4) begin r_addr[c_nr] = mem_addr; r_at[c_nr] = c_cyc; end
                c_nr++;
            end
            c_cyc++;
            tick();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick(); tick();
        m_bits = '0; m_nmi = 0; m_ib = 1; m_jam = 0;
        rst_n = 1'b1;
        collect();
        check(c_cyc == 7, "R1 reset busy length", c_cyc, 7);
        check(c_nw == 0, "R1 reset writes", c_nw, 0);
        check(c_nr == 2, "R1 reset read count", c_nr, 2);
        check(r_addr[0] == 16'hFFFC && r_at[0] == 5, "R1 reset low read", r_addr[0], 16'hFFFC);
        check(r_addr[1] == 16'hFFFD && r_at[1] == 6, "R1 reset high read", r_addr[1], 16'hFFFD);
        check(pc_out == 16'h8000, "R1 reset pc", pc_out, 16'h8000);
        check(status_out == 8'h04, "R1 reset status", status_out, 8'h04);
        check(sp_out == 8'h00, "R1 reset sp", sp_out, 8'h00);
        check(irq_pending == 1'b0, "R1 reset source bits", irq_pending, 0);
    endtask

    task automatic set_clr(input logic [SRC-1:0] s, input logic [SRC-1:0] c);
        irq_set = s; irq_clr = c;
        tick();
        irq_set = '0; irq_clr = '0;
        m_bits = (m_bits & ~c) | s;
        check(irq_pending == (m_bits != 0), "R9 pending flag", irq_pending, m_bits != 0);
    endtask

    task automatic nmi_pulse();
        nmi_req = 1'b1; tick(); nmi_req = 1'b0; m_nmi = 1;
    endtask

    task automatic jam_pulse();
        jam_strobe = 1'b1; tick(); jam_strobe = 1'b0; m_jam = 1;
    endtask

    task automatic do_boundary(input logic [15:0] pc, input logic [7:0] st,
                               input logic [7:0] sp, input bit hold, input string tag);
        int kind;
        logic [15:0] vec;
        logic [7:0] exp_st, exp_ps;
        kind = 0;
        if (!m_jam) begin
            if (m_nmi) kind = 1;
            else if (m_bits != 0 && !m_ib) kind = 2;
        end
        pc_in = pc; status_in = st; sp_in = sp; insn_boundary = 1'b1;
        tick();
        if (!hold) insn_boundary = 1'b0;
        check(busy == (kind != 0), tag, busy, kind != 0);
        if (kind == 0 || !busy) begin
            insn_boundary = 1'b0;
            if (kind == 0) m_ib = st[2];
        end else begin
            collect();
            insn_boundary = 1'b0;
            vec    = (kind == 1) ? 16'hFFFA : 16'hFFFE;
            exp_ps = (st & 8'hEF) | 8'h20;
            exp_st = (st & 8'hEF) | ((kind == 2) ? 8'h04 : 8'h00);
            check(c_cyc == 7, "R2 busy length", c_cyc, 7);
            check(c_nw == 3, "R3 push count", c_nw, 3);
            for (int i = 0; i < 3; i++) begin
                check(w_addr[i] == {8'h01, 8'(sp - 8'(i))}, "R3 push address",
                      w_addr[i], {8'h01, 8'(sp - 8'(i))});
                check(w_at[i] == 2 + i, "R2 push cycle", w_at[i], 2 + i);
            end
            check(w_data[0] == pc[15:8], "R4 pushed pc high", w_data[0], pc[15:8]);
            check(w_data[1] == pc[7:0], "R4 pushed pc low", w_data[1], pc[7:0]);
            check(w_data[2] == exp_ps, "R4 pushed status", w_data[2], exp_ps);
            check(c_nr == 2, "R2 read count", c_nr, 2);
            check(r_addr[0] == vec && r_at[0] == 5, (kind == 1) ? "R5 vector low" : "R6 vector low",
                  r_addr[0], vec);
            check(r_addr[1] == vec + 16'd1 && r_at[1] == 6, (kind == 1) ? "R5 vector high" : "R6 vector high",
                  r_addr[1], vec + 16'd1);
            check(pc_out == {vec_byte(vec + 16'd1), vec_byte(vec)}, (kind == 1) ? "R5 pc" : "R6 pc",
                  pc_out, {vec_byte(vec + 16'd1), vec_byte(vec)});
            check(status_out == exp_st, (kind == 1) ? "R5 status" : "R6 status", status_out, exp_st);
            check(sp_out == sp - 8'd3, "R3 final sp", sp_out, sp - 8'd3);
            if (hold) begin
                tick();
                check(busy == 1'b0, "R12 boundary during busy ignored", busy, 0);
            end
            if (kind == 1) m_nmi = 0;
            m_ib = exp_st[2];
        end
        check(irq_pending == (m_bits != 0), "R9 pending after boundary", irq_pending, m_bits != 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        tick();
        check(busy == 1'b1, "R1 busy during reset", busy, 1);
        check(mem_wr == 1'b0, "R1 no write during reset", mem_wr, 0);
        do_reset();

        // R9: same-cycle set and clear, set wins; then release
        set_clr(4'b0001, 4'b0001);
        set_clr(4'b0000, 4'b0001);
        // R12: idle boundary leaves busy low
        do_boundary(16'h1234, 8'h00, 8'hFD, 0, "R12 idle boundary");

        // R8: mask reference from previous boundary
        do_reset();
        set_clr(4'b0100, 4'b0000);
        do_boundary(16'h2000, 8'h00, 8'hFD, 0, "R8 masked by earlier I");
        do_boundary(16'h2001, 8'h04, 8'hFD, 0, "R8 taken with earlier I clear");
        do_boundary(16'h2002, 8'h00, 8'hFA, 0, "R8 masked after entry");
        do_boundary(16'h2003, 8'h00, 8'hFA, 0, "R8 taken again");

        // R7 and R12: NMI first while IRQ pending, boundary held through busy
        nmi_pulse();
        do_boundary(16'hBEEF, 8'hD3, 8'hF7, 1, "R7 nmi first");
        do_boundary(16'hBEF0, 8'h00, 8'hF4, 0, "R7 irq afterwards");
        set_clr(4'b0000, 4'b1111);

        // R10: NMI held across cycles, consumed once
        nmi_pulse();
        set_clr(4'b0010, 4'b0000);
        set_clr(4'b0000, 4'b0010);
        do_boundary(16'h4455, 8'h04, 8'h01, 0, "R10 held nmi taken");
        do_boundary(16'h4456, 8'h00, 8'hFE, 0, "R10 nmi consumed");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 4)      set_clr(SRC'($urandom), SRC'($urandom));
            else if (sel == 4) nmi_pulse();
            else do_boundary(16'($urandom), 8'($urandom), 8'($urandom), sel == 9, "R7 R8 random boundary");
        end

        // R11: jam blocks everything until reset
        jam_pulse();
        nmi_pulse();
        set_clr(4'b1000, 4'b0000);
        do_boundary(16'h5000, 8'h00, 8'hFD, 0, "R11 jammed nmi blocked");
        do_boundary(16'h5001, 8'h00, 8'hFD, 0, "R11 jammed irq blocked");
        do_reset();
        set_clr(4'b1000, 4'b0000);
        do_boundary(16'h6000, 8'h00, 8'hFD, 0, "R11 masked after reset");
        do_boundary(16'h6001, 8'h00, 8'hFD, 0, "R11 entry after reset clears jam");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule